// File: doc/BRIEF.md
# Mesh Router Output Port with Elastic Buffering

This block is one output port of a mesh router that keeps no input buffers and no credit counters. Each router input offers its head flit through a ready/valid handshake from an upstream elastic buffer. The output port decides for itself which input to serve: it builds a request vector from the head flits, arbitrates round-robin among the requesters, and pulls the winning flit across its crossbar slice into a small output elastic buffer that drives the outgoing channel.

Routing is dimension-order, X before Y, and computed one hop ahead. A head flit already names the output it wants at this router. The port computes which output the flit will use at the next router and writes that into the head flit as it passes. Arbitration for a flit finishes one cycle before the flit enters the output buffer. The output buffer has three slots, so the one-cycle gap costs no throughput. Once the head flit of a multi-flit packet wins, the port serves only that input until the packet's tail has gone through.

Flit layout (64 bits by default): bits [63:62] hold the kind (00 head, 01 body, 10 tail, 11 single-flit packet). Bits [61:59] hold the look-ahead port (0 local, 1 +X, 2 -X, 3 +Y, 4 -Y). Bits [58:56] hold the destination X and bits [55:53] the destination Y. The rest is payload.

Top module: `mesh_out_port`

## Requirements
- R1: While reset is asserted, `out_valid` and every bit of `in_ready` are 0, even if inputs offer flits.
- R2: An input requests this port only when it is valid and either holds the packet lock, or presents a head (00) or single (11) flit whose look-ahead field equals OUT_PORT. A body or tail flit from an input without the lock is ignored, as is a head whose look-ahead field names another port: `in_ready` stays 0 and nothing reaches the output.
- R3: Requesters are served round-robin. After reset input 0 has top priority, and priority moves to the input after the winner only in a cycle when a grant is given.
- R4: After a head (00) flit from input i is granted, only input i is granted until its tail (10) flit has been granted.
- R5: `in_ready[i]` is high only when input i is valid, granted, and the output buffer is sure to have a slot for the flit. Counted as taken are the slots occupied and the flit already granted but not yet written. A flit leaves an input exactly when `in_valid` and `in_ready` are both high.
- R6: A flit accepted from an input at a clock edge is accepted by the output at the second clock edge after it, when the buffer is empty and `out_ready` is high.
- R7: The output buffer holds three flits. With `out_ready` low, exactly three flits are accepted from the inputs, after which `in_ready` stays 0 and `out_valid` stays 1.
- R8: Flits leave in the order they were accepted. While `out_valid` is 1 and `out_ready` is 0, `out_flit` does not change.
- R9: For a head or single flit, the port replaces the look-ahead field with the dimension-order port at the neighbouring router that OUT_PORT leads to. That port is +X if dest X is larger than the neighbour's X, -X if smaller; otherwise +Y or -Y by Y; otherwise local. Body and tail flits pass unchanged.
- R10: With `out_ready` held high and one input streaming, the port forwards one flit per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_IN | Input i offers a flit |
| in_ready | output | N_IN | Input i's flit is taken this cycle |
| in_flit | input | N_IN x DATA_W | Head flit offered by each input |
| out_valid | output | 1 | Output buffer is non-empty |
| out_ready | input | 1 | Downstream has a free slot |
| out_flit | output | DATA_W | Flit at the head of the output buffer |

## Verification
The bench goes after packet interleaving. Two inputs compete while one of them is mid-packet. A port without the lock would grant the other input's single flit and leave the body flits stranded, because body flits never request on their own. It fills the output buffer against a stalled channel. A design that counted only occupied slots and ignored the flit in flight would accept a fourth flit and overwrite one. It also streams back to back from one input, where a design that lacked the third slot, or waited for the write before granting again, would forward only every other cycle. A table of destinations covers every branch of the look-ahead route: wrong axis order or a neighbour coordinate off by one shows up as a wrong port field.

// File: rtl/mor_pkg.sv
`timescale 1ns/1ps
package mor_pkg;

   typedef enum logic [1:0] {
      KIND_HEAD = 2'd0,
      KIND_BODY = 2'd1,
      KIND_TAIL = 2'd2,
      KIND_SOLO = 2'd3
   } flit_kind_e;

   localparam int PORT_W = 3;

   localparam logic [PORT_W-1:0] DIR_LOCAL = 3'd0;
   localparam logic [PORT_W-1:0] DIR_XPOS  = 3'd1;
   localparam logic [PORT_W-1:0] DIR_XNEG  = 3'd2;
   localparam logic [PORT_W-1:0] DIR_YPOS  = 3'd3;
   localparam logic [PORT_W-1:0] DIR_YNEG  = 3'd4;

endpackage

// File: rtl/mor_req_gen.sv
`timescale 1ns/1ps
module mor_req_gen
   import mor_pkg::*;
#(
   parameter int N_IN     = 5,
   parameter int DATA_W   = 64,
   parameter int OUT_PORT = 1
) (
   input  logic [N_IN-1:0]             in_valid,
   input  logic [N_IN-1:0][DATA_W-1:0] in_flit,
   input  logic                        lock_q,
   input  logic [N_IN-1:0]             owner_q,
   output logic [N_IN-1:0]             req
);
   localparam int KIND_LSB = DATA_W - 2;
   localparam int LAH_LSB  = KIND_LSB - PORT_W;

   for (genvar i = 0; i < N_IN; i++) begin : g_req
      logic [1:0]        kind;
      logic [PORT_W-1:0] lah;
      logic              opens;
      assign kind  = in_flit[i][KIND_LSB +: 2];
      assign lah   = in_flit[i][LAH_LSB +: PORT_W];
      assign opens = ((kind == KIND_HEAD) || (kind == KIND_SOLO)) &&
                     (lah == PORT_W'(OUT_PORT));
      assign req[i] = in_valid[i] & (lock_q ? owner_q[i] : opens);
   end

endmodule

// File: rtl/mor_rr_arb.sv
`timescale 1ns/1ps
module mor_rr_arb #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         en,
   output logic [N-1:0] gnt
);
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] win;
   logic [N-1:0]     pick;
   logic             found;

   always_comb begin
      pick  = '0;
      win   = '0;
      found = 1'b0;
      for (int k = 0; k < N; k++) begin
         int j;
         j = int'(ptr_q) + k;
         if (j >= N) j = j - N;
         if (!found && req[j]) begin
            pick[j] = 1'b1;
            win     = IDX_W'(j);
            found   = 1'b1;
         end
      end
   end

   assign gnt = en ? pick : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (en && found) begin
         ptr_q <= (win == IDX_W'(N-1)) ? '0 : win + 1'b1;
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)); // R3
   AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0); // R5
   AST_PTR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0) |=> $stable(ptr_q)); // R3

endmodule

// File: rtl/mor_lah_route.sv
`timescale 1ns/1ps
module mor_lah_route
   import mor_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int COORD_W  = 3,
   parameter int MY_X     = 2,
   parameter int MY_Y     = 2,
   parameter int OUT_PORT = 1
) (
   input  logic [DATA_W-1:0] flit_i,
   output logic [DATA_W-1:0] flit_o
);
   localparam int KIND_LSB = DATA_W - 2;
   localparam int LAH_LSB  = KIND_LSB - PORT_W;
   localparam int DX_LSB   = LAH_LSB - COORD_W;
   localparam int DY_LSB   = DX_LSB - COORD_W;
   localparam int NX = MY_X + ((OUT_PORT == 1) ? 1 : 0) - ((OUT_PORT == 2) ? 1 : 0);
   localparam int NY = MY_Y + ((OUT_PORT == 3) ? 1 : 0) - ((OUT_PORT == 4) ? 1 : 0);

   if (OUT_PORT == 0) begin : g_eject
      assign flit_o = flit_i;
   end else begin : g_hop
      logic [1:0]         kind;
      logic [COORD_W-1:0] dx, dy;
      logic [PORT_W-1:0]  nxt;
      assign kind = flit_i[KIND_LSB +: 2];
      assign dx   = flit_i[DX_LSB +: COORD_W];
      assign dy   = flit_i[DY_LSB +: COORD_W];

      always_comb begin
         if (dx > COORD_W'(NX))      nxt = DIR_XPOS;
         else if (dx < COORD_W'(NX)) nxt = DIR_XNEG;
         else if (dy > COORD_W'(NY)) nxt = DIR_YPOS;
         else if (dy < COORD_W'(NY)) nxt = DIR_YNEG;
         else                        nxt = DIR_LOCAL;
         flit_o = flit_i;
         if ((kind == KIND_HEAD) || (kind == KIND_SOLO))
            flit_o[LAH_LSB +: PORT_W] = nxt;
      end
   end

endmodule

// File: rtl/mor_out_eb.sv
`timescale 1ns/1ps
module mor_out_eb #(
   parameter int W     = 64,
   parameter int DEPTH = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr,
   input  logic [W-1:0]                  wr_data,
   input  logic                          rd_ready,
   output logic                          valid,
   output logic [W-1:0]                  data,
   output logic [$clog2(DEPTH+1)-1:0]    count
);
   localparam int CNT_W = $clog2(DEPTH+1);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [CNT_W-1:0] cnt_q;
   logic             rd;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
   endfunction

   assign valid = (cnt_q != '0);
   assign data  = mem[rp_q];
   assign count = cnt_q;
   assign rd    = valid & rd_ready;

   always_ff @(posedge clk) begin
      if (wr) mem[wp_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr) wp_q <= bump(wp_q);
         if (rd) rp_q <= bump(rp_q);
         if (wr && !rd)      cnt_q <= cnt_q + 1'b1;
         else if (rd && !wr) cnt_q <= cnt_q - 1'b1;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> (cnt_q < CNT_W'(DEPTH))); // R7
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !rd_ready) |=> (valid && $stable(data))); // R8

endmodule

// File: rtl/mesh_out_port.sv
`timescale 1ns/1ps
module mesh_out_port
   import mor_pkg::*;
#(
   parameter int N_IN     = 5,
   parameter int DATA_W   = 64,
   parameter int MESH_W   = 5,
   parameter int MESH_H   = 5,
   parameter int MY_X     = 2,
   parameter int MY_Y     = 2,
   parameter int OUT_PORT = 1,
   parameter int DEPTH    = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_IN-1:0]             in_valid,
   output logic [N_IN-1:0]             in_ready,
   input  logic [N_IN-1:0][DATA_W-1:0] in_flit,
   output logic                        out_valid,
   input  logic                        out_ready,
   output logic [DATA_W-1:0]           out_flit
);
   localparam int COORD_W  = $clog2((MESH_W > MESH_H) ? MESH_W : MESH_H);
   localparam int CNT_W    = $clog2(DEPTH+1);
   localparam int KIND_LSB = DATA_W - 2;

   if (N_IN < 2) begin : g_chk_nin
      $error("mesh_out_port: N_IN must be at least 2");
   end
   if (DEPTH < 3) begin : g_chk_depth
      $error("mesh_out_port: DEPTH below 3 cannot cover early arbitration");
   end
   if (DATA_W < 2 + PORT_W + 2*COORD_W + 1) begin : g_chk_w
      $error("mesh_out_port: DATA_W too narrow for the header");
   end
   if ((OUT_PORT == 1 && MY_X >= MESH_W-1) || (OUT_PORT == 2 && MY_X == 0) ||
       (OUT_PORT == 3 && MY_Y >= MESH_H-1) || (OUT_PORT == 4 && MY_Y == 0) ||
       (OUT_PORT > 4)) begin : g_chk_port
      $error("mesh_out_port: OUT_PORT leads off the mesh");
   end

   logic [N_IN-1:0]   req, gnt, owner_q;
   logic              lock_q;
   logic              trav_vld_q;
   logic [DATA_W-1:0] trav_flit_q;
   logic [DATA_W-1:0] sel_flit, fwd_flit;
   logic [CNT_W-1:0]  occ;
   logic              space_ok, accept;
   logic [1:0]        sel_kind;

   mor_req_gen #(.N_IN(N_IN), .DATA_W(DATA_W), .OUT_PORT(OUT_PORT)) u_req (
      .in_valid(in_valid), .in_flit(in_flit),
      .lock_q(lock_q), .owner_q(owner_q), .req(req));

   // a slot is reserved for the flit already in traversal; pops are not counted
   assign space_ok = rst_n &&
                     (({1'b0, occ} + (CNT_W+1)'(trav_vld_q)) < (CNT_W+1)'(DEPTH));

   mor_rr_arb #(.N(N_IN)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req), .en(space_ok), .gnt(gnt));

   assign accept   = |gnt;
   assign in_ready = gnt;

   always_comb begin
      sel_flit = '0;
      for (int i = 0; i < N_IN; i++)
         sel_flit = sel_flit | ({DATA_W{gnt[i]}} & in_flit[i]);
   end
   assign sel_kind = sel_flit[KIND_LSB +: 2];

   mor_lah_route #(.DATA_W(DATA_W), .COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y),
                   .OUT_PORT(OUT_PORT)) u_route (
      .flit_i(sel_flit), .flit_o(fwd_flit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trav_vld_q <= 1'b0;
         lock_q     <= 1'b0;
         owner_q    <= '0;
      end else begin
         trav_vld_q <= accept;
         if (accept) begin
            if (sel_kind == KIND_HEAD) begin
               lock_q  <= 1'b1;
               owner_q <= gnt;
            end else if (sel_kind == KIND_TAIL) begin
               lock_q  <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (accept) trav_flit_q <= fwd_flit;
   end

   mor_out_eb #(.W(DATA_W), .DEPTH(DEPTH)) u_oeb (
      .clk(clk), .rst_n(rst_n), .wr(trav_vld_q), .wr_data(trav_flit_q),
      .rd_ready(out_ready), .valid(out_valid), .data(out_flit), .count(occ));

   AST_LOCK_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |-> ((in_ready & ~owner_q) == '0)); // R4
   AST_READY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready & ~in_valid) == '0); // R5
   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == CNT_W'(DEPTH)) |-> (in_ready == '0)); // R7

endmodule

// File: tb/mesh_out_port_test.sv
`timescale 1ns/1ps
module mesh_out_port_test;
   localparam int NI = 5;
   localparam int DW = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [NI-1:0]         in_valid, in_ready;
   logic [NI-1:0][DW-1:0] in_flit;
   logic                  out_valid, out_ready;
   logic [DW-1:0]         out_flit;

   mesh_out_port #(.N_IN(NI), .DATA_W(DW), .MY_X(2), .MY_Y(2), .OUT_PORT(1)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_flit(in_flit), .out_valid(out_valid), .out_ready(out_ready),
      .out_flit(out_flit));

   logic [DW-1:0] q [NI][$];
   logic [DW-1:0] rx [$];
   int            rx_cyc [$];
   int            hs_cyc [NI];
   int            hs_cnt [NI];
   int            cyc = 0;
   int            bad_rdy = 0;
   int            checks = 0;
   int            failures = 0;

   // neighbour is (3,2); fields: [63:62] kind, [61:59] port, [58:56] x, [55:53] y
   localparam logic [15:0] VEC [8] = '{
      16'h0421, 16'h1320, 16'h2002, 16'h3343,
      16'h4304, 16'h0142, 16'h1401, 16'h2333 };

   function automatic logic [DW-1:0] mk(input logic [1:0] k, input logic [2:0] p,
                                        input logic [2:0] x, input logic [2:0] y,
                                        input int tag);
      return {k, p, x, y, 53'(tag)};
   endfunction

   function automatic logic [DW-1:0] setp(input logic [DW-1:0] f, input logic [2:0] p);
      logic [DW-1:0] r;
      r = f;
      r[61:59] = p;
      return r;
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < NI; i++) begin
            if (in_valid[i] && in_ready[i]) begin
               void'(q[i].pop_front());
               hs_cnt[i]++;
               hs_cyc[i] = cyc;
            end
            if (in_ready[i] && !in_valid[i]) bad_rdy++;
         end
         if (out_valid && out_ready) begin
            rx.push_back(out_flit);
            rx_cyc.push_back(cyc);
         end
      end
      cyc++;
   end

   always @(negedge clk) begin
      for (int i = 0; i < NI; i++) begin
         in_valid[i] = (q[i].size() > 0);
         in_flit[i]  = (q[i].size() > 0) ? q[i][0] : '0;
      end
   end

   always @(posedge clk) begin
      if (cyc > 20000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic do_reset(input logic ordy);
      rst_n = 1'b0;
      out_ready = ordy;
      @(posedge clk); #1;
      for (int i = 0; i < NI; i++) begin
         q[i].delete();
         hs_cnt[i] = 0;
      end
      @(posedge clk); #1;
      rx.delete();
      rx_cyc.delete();
      rst_n = 1'b1;
   endtask

   task automatic wait_rx(input int n);
      int guard = 0;
      while (rx.size() < n && guard < 300) begin
         @(posedge clk);
         guard++;
      end
      #1;
      chk(rx.size() >= n, "R8", "flits received", 64'(rx.size()), 64'(n));
   endtask

   initial begin
      in_valid = '0;
      in_flit = '0;
      out_ready = 1'b0;
      rst_n = 1'b0;

      // R1: reset holds everything quiet even with a flit offered
      q[0].push_back(mk(2'd3, 3'd1, 3'd4, 3'd2, 1));
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk(in_ready == '0, "R1", "in_ready in reset", 64'(in_ready), 0);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 0);
      do_reset(1'b1);

      // R9 / R6: route table, one single flit per entry
      foreach (VEC[k]) begin
         int src;
         logic [DW-1:0] f;
         src = int'(VEC[k][15:12]);
         f = mk(2'd3, 3'd1, VEC[k][10:8], VEC[k][6:4], 100 + k);
         rx.delete();
         rx_cyc.delete();
         @(posedge clk); #1;
         q[src].push_back(f);
         wait_rx(1);
         chk(rx[0] == setp(f, VEC[k][2:0]), "R9", "rewritten head", rx[0],
             setp(f, VEC[k][2:0]));
         chk(rx_cyc[0] - hs_cyc[src] == 2, "R6", "in-to-out edges",
             64'(rx_cyc[0] - hs_cyc[src]), 2);
      end

      // R2: wrong port head and unlocked body are ignored
      do_reset(1'b1);
      q[0].push_back(mk(2'd3, 3'd2, 3'd4, 3'd2, 7));
      q[1].push_back(mk(2'd1, 3'd1, 3'd4, 3'd2, 8));
      repeat (8) @(posedge clk);
      @(negedge clk); #1;
      chk(hs_cnt[0] == 0 && hs_cnt[1] == 0, "R2", "ignored flits taken",
          64'(hs_cnt[0] + hs_cnt[1]), 0);
      chk(rx.size() == 0 && !out_valid, "R2", "output after ignored flits",
          64'(rx.size()), 0);

      // R3: round robin across inputs 0, 2, 4
      do_reset(1'b1);
      for (int n = 0; n < 2; n++) begin
         q[0].push_back(mk(2'd3, 3'd1, 3'd4, 3'd2, 16*0 + n));
         q[2].push_back(mk(2'd3, 3'd1, 3'd4, 3'd2, 16*2 + n));
         q[4].push_back(mk(2'd3, 3'd1, 3'd4, 3'd2, 16*4 + n));
      end
      wait_rx(6);
      for (int n = 0; n < 6; n++) begin
         int exp_tag;
         exp_tag = 16 * (2 * (n % 3)) + n / 3;
         chk(rx.size() > n && rx[n][52:0] == 53'(exp_tag), "R3", "rr order tag",
             (rx.size() > n) ? 64'(rx[n][52:0]) : 0, 64'(exp_tag));
      end

      // R4: packet on input 3 is not split by a single on input 0
      do_reset(1'b1);
      @(posedge clk); #1;
      q[3].push_back(mk(2'd0, 3'd1, 3'd3, 3'd4, 30));
      q[3].push_back(mk(2'd1, 3'd5, 3'd0, 3'd0, 31));
      q[3].push_back(mk(2'd1, 3'd5, 3'd0, 3'd0, 32));
      q[3].push_back(mk(2'd2, 3'd5, 3'd0, 3'd0, 33));
      @(posedge clk); #1;
      q[0].push_back(mk(2'd3, 3'd1, 3'd0, 3'd0, 40));
      wait_rx(5);
      chk(rx[0] == mk(2'd0, 3'd3, 3'd3, 3'd4, 30), "R4", "head first",
          rx[0], mk(2'd0, 3'd3, 3'd3, 3'd4, 30));
      chk(rx[1] == mk(2'd1, 3'd5, 3'd0, 3'd0, 31), "R4", "body 1 untouched",
          rx[1], mk(2'd1, 3'd5, 3'd0, 3'd0, 31));
      chk(rx[2] == mk(2'd1, 3'd5, 3'd0, 3'd0, 32), "R9", "body 2 untouched",
          rx[2], mk(2'd1, 3'd5, 3'd0, 3'd0, 32));
      chk(rx[3] == mk(2'd2, 3'd5, 3'd0, 3'd0, 33), "R4", "tail before other input",
          rx[3], mk(2'd2, 3'd5, 3'd0, 3'd0, 33));
      chk(rx[4] == mk(2'd3, 3'd2, 3'd0, 3'd0, 40), "R4", "single after tail",
          rx[4], mk(2'd3, 3'd2, 3'd0, 3'd0, 40));

      // R7 / R5 / R8: stalled channel
      do_reset(1'b0);
      for (int n = 0; n < 5; n++) q[1].push_back(mk(2'd3, 3'd1, 3'd4, 3'd2, 50 + n));
      repeat (10) @(posedge clk);
      @(negedge clk); #1;
      chk(hs_cnt[1] == 3, "R7", "flits taken while stalled", 64'(hs_cnt[1]), 3);
      chk(in_ready == '0, "R5", "in_ready when full", 64'(in_ready), 0);
      chk(out_valid == 1'b1, "R7", "out_valid when full", 64'(out_valid), 1);
      begin
         logic [DW-1:0] held;
         held = out_flit;
         @(negedge clk); #1;
         chk(out_flit == held, "R8", "stalled output stable", out_flit, held);
      end
      out_ready = 1'b1;
      wait_rx(5);
      for (int n = 0; n < 5; n++)
         chk(rx[n][52:0] == 53'(50 + n), "R8", "order after stall",
             64'(rx[n][52:0]), 64'(50 + n));

      // R10: back-to-back stream
      do_reset(1'b1);
      for (int n = 0; n < 8; n++) q[4].push_back(mk(2'd3, 3'd1, 3'd4, 3'd2, 70 + n));
      wait_rx(8);
      chk(rx_cyc[7] - rx_cyc[0] == 7, "R10", "edges for 8 flits",
          64'(rx_cyc[7] - rx_cyc[0]), 7);

      chk(bad_rdy == 0, "R5", "ready without valid", 64'(bad_rdy), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule